// File: doc/BRIEF.md
# Flash Programming Status and Polling Unit

This block holds the completion and status reporting for an on-chip flash programming interface. It accepts four commands: load a byte into the page buffer, write a byte, program the buffered page, and erase. It runs each programming or erase cycle for a fixed number of clocks, set by a parameter. The flash array itself is not modelled. Only the byte that a polling read would return is kept.

Software tracks progress in two ways. It can read an 8-bit status word. It can also poll the last written location. While a cycle runs, the polled value is the expected byte with its top bit flipped. Once the cycle ends, the true byte comes back. A brownout input passes through a two-flop synchronizer. While it is asserted, new memory writes are blocked, and any cycle it overlaps is marked as failed.

Top module: `flash_poll_unit`

## Requirements
- R1: Status word layout: bit 3 = buffer-unused flag (LOAD), bit 2 = SUCCESS, bit 1 = write-enabled flag (WRTINH, high when writes allowed), bit 0 = ready flag (BUSY, high when idle); bits 7..4 always read 0.
- R2: After reset with brownout low, the status word is 0x0F and the polled value is 0xFF.
- R3: For each clock in which a write (op 1) cycle is running, the polled value is the written byte with bit 7 inverted. After the cycle ends it is the byte itself.
- R4: A page program (op 2) polls the byte of the most recent load-buffer command (op 0), not any earlier loaded byte.
- R5: An erase (op 3) polls 0x7F while running and 0xFF after completion.
- R6: A load-buffer command clears LOAD. The next accepted write, program or erase sets LOAD again.
- R7: SUCCESS goes low in the cycle after a write, program or erase is accepted. It goes high at completion only if the synchronized brownout was never high during the cycle.
- R8: Brownout reaches the status word two clocks after it rises. It then holds WRTINH low and BUSY low. A cycle it overlaps ends with SUCCESS low.
- R9: Write, program and erase commands are ignored while WRTINH is low or while a cycle is running. The polled value and the flags do not change.
- R10: A cycle keeps BUSY low for exactly PROG_CYCLES clocks after the accepting edge.
- R11: A load-buffer command issued while a cycle runs is ignored. LOAD and the polled value are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, one clock per command |
| cmdOp | input | 2 | 0 load buffer, 1 write byte, 2 program page, 3 erase |
| cmdData | input | DATA_W | Byte for load-buffer and write commands |
| brownout | input | 1 | Asynchronous low-supply indication |
| pollData | output | DATA_W | Value returned by a poll of the last written location |
| statusReg | output | 8 | Status word |

## Verification
The bench builds the unit with PROG_CYCLES = 5 and the default 8-bit data width. The short cycle lets many complete cycles fit into one run. With it, brownout can be raised before a command, in the middle of a cycle, and on the completion edge itself. Random commands then land often both inside running cycles and between them. That exercises the ignore rules and the rule that a failed cycle leaves SUCCESS low.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [1:0] {
    OP_LOADBUF = 2'd0,
    OP_WRITE   = 2'd1,
    OP_PROGRAM = 2'd2,
    OP_ERASE   = 2'd3
  } cmdOpE;

  typedef struct packed {
    logic captureData;
    logic eraseTarget;
    logic clearLoad;
    logic setLoad;
    logic cycleStart;
    logic cycleEnd;
    logic endOk;
  } strobeT;

  localparam int STATUS_W = 8;

endpackage

// File: rtl/fpu_sync.sv
module fpu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/fpu_ctrl.sv
module fpu_ctrl
  import flash_poll_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       bodSync,
  output strobeT     strb,
  output logic       inProgress
);
  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             bodSeen;
  logic             acceptLoad;
  logic             acceptMem;

  assign acceptLoad = cmdValid && (cmdOp == OP_LOADBUF) && !inProgress;
  assign acceptMem  = cmdValid && (cmdOp != OP_LOADBUF) && !inProgress && !bodSync;

  always_comb begin
    strb             = '0;
    strb.clearLoad   = acceptLoad;
    strb.captureData = acceptLoad || (acceptMem && cmdOp == OP_WRITE);
    strb.eraseTarget = acceptMem && (cmdOp == OP_ERASE);
    strb.setLoad     = acceptMem;
    strb.cycleStart  = acceptMem;
    strb.cycleEnd    = inProgress && (cnt == '0);
    strb.endOk       = !(bodSeen || bodSync);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inProgress <= 1'b0;
      cnt        <= '0;
      bodSeen    <= 1'b0;
    end else if (strb.cycleStart) begin
      inProgress <= 1'b1;
      cnt        <= LAST;
      bodSeen    <= 1'b0;
    end else if (strb.cycleEnd) begin
      inProgress <= 1'b0;
    end else if (inProgress) begin
      cnt <= cnt - 1'b1;
      if (bodSync) bodSeen <= 1'b1;
    end
  end

  // R9: no cycle may begin while writes are inhibited
  p_no_start_inhibited_r9: assert property (@(posedge clk) disable iff (!rstN)
    bodSync |-> !strb.cycleStart);

  // R10: the countdown never exceeds its programmed length
  p_counter_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    inProgress |-> (cnt <= LAST));

  // R8: brownout seen mid-cycle spoils the completion
  p_bod_fails_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inProgress && bodSync && !strb.cycleEnd) |=> !strb.endOk);

  // R10: a started cycle is in progress on the next clock
  p_start_runs_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.cycleStart |=> inProgress);
endmodule

// File: rtl/fpu_datapath.sv
module fpu_datapath
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [DATA_W-1:0]   cmdData,
  input  logic                inProgress,
  input  logic                bodSync,
  output logic [DATA_W-1:0]   pollData,
  output logic [STATUS_W-1:0] statusReg
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] target;
  logic              loadFlag;
  logic              successFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target      <= '1;
      loadFlag    <= 1'b1;
      successFlag <= 1'b1;
    end else begin
      if (strb.eraseTarget)      target <= '1;
      else if (strb.captureData) target <= cmdData;

      if (strb.clearLoad)    loadFlag <= 1'b0;
      else if (strb.setLoad) loadFlag <= 1'b1;

      if (strb.cycleStart)    successFlag <= 1'b0;
      else if (strb.cycleEnd) successFlag <= strb.endOk;
    end
  end

  assign pollData  = inProgress ? (target ^ MSB_MASK) : target;
  assign statusReg = {4'b0000, loadFlag, successFlag, !bodSync, !(inProgress || bodSync)};

  // R7: accepting a cycle drops SUCCESS
  p_start_clears_success_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.cycleStart |=> !statusReg[2]);

  // R6: load-buffer command drops LOAD
  p_load_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearLoad |=> !statusReg[3]);

  // R5: erase polls all ones with the top bit flipped
  p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseTarget |=> (pollData == ~MSB_MASK));
endmodule

// File: rtl/flash_poll_unit.sv
module flash_poll_unit
  import flash_poll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              brownout,
  output logic [DATA_W-1:0] pollData,
  output logic [7:0]        statusReg
);
  strobeT strb;
  logic   bodSync;
  logic   inProgress;

  fpu_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(brownout), .syncOut(bodSync));

  fpu_ctrl #(.PROG_CYCLES(PROG_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .bodSync(bodSync), .strb(strb), .inProgress(inProgress));

  fpu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdData(cmdData),
    .inProgress(inProgress), .bodSync(bodSync),
    .pollData(pollData), .statusReg(statusReg));

  // R8: write inhibit forces the ready flag low
  p_inhibit_forces_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statusReg[1] |-> !statusReg[0]);

  // R1: upper status bits stay clear
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[7:4] == 4'b0000);
endmodule

// File: tb/flash_poll_unit_tb.sv
module flash_poll_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdData = 8'd0;
  logic       brownout = 1'b0;
  logic [7:0] pollData;
  logic [7:0] statusReg;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model state
  logic mSync1 = 0, mSync2 = 0, mInProg = 0, mSeen = 0, mLoad = 1, mSucc = 1;
  int   mCnt = 0;
  logic [7:0] mTarget = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_poll_unit #(.DATA_W(8), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .brownout(brownout),
    .pollData(pollData), .statusReg(statusReg));

  function automatic logic [7:0] expStatus();
    return {4'b0000, mLoad, mSucc, !mSync2, !(mInProg || mSync2)};
  endfunction

  function automatic logic [7:0] expPoll();
    return mInProg ? (mTarget ^ 8'h80) : mTarget;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(input logic v, input logic [1:0] op, input logic [7:0] d, input logic b);
    logic accLoad, accMem, endNow;
    accLoad = v && op == 2'd0 && !mInProg;
    accMem  = v && op != 2'd0 && !mInProg && !mSync2;
    endNow  = mInProg && mCnt == 0;
    if (accLoad) begin mTarget = d; mLoad = 0; end
    if (accMem) begin
      mLoad = 1; mSucc = 0; mInProg = 1; mCnt = PROG - 1; mSeen = 0;
      if (op == 2'd1) mTarget = d;
      else if (op == 2'd3) mTarget = 8'hFF;
    end else if (endNow) begin
      mInProg = 0; mSucc = !(mSeen || mSync2);
    end else if (mInProg) begin
      mCnt--; if (mSync2) mSeen = 1;
    end
    mSync2 = mSync1; mSync1 = b;
  endtask

  // drive at negedge, step model after the edge, compare at next negedge
  task automatic tick(input logic v, input logic [1:0] op, input logic [7:0] d, input logic b);
    cmdValid = v; cmdOp = op; cmdData = d; brownout = b;
    @(posedge clk);
    modelStep(v, op, d, b);
    @(negedge clk);
    cmdValid = 0;
    chk("R1 status", statusReg, expStatus());
    chk("R3 poll", pollData, expPoll());
  endtask

  task automatic idle(input int n, input logic b);
    for (int i = 0; i < n; i++) tick(0, 2'd0, 8'h00, b);
  endtask

  initial begin
    int busyCnt;
    process::self().srandom(32'h5eed_1234);
    @(negedge clk); @(negedge clk);
    chk("R2 reset status", statusReg, 8'h0F);
    chk("R2 reset poll", pollData, 8'hFF);
    rstN = 1;
    @(negedge clk);

    // R4 / R6: page program polls last loaded byte
    tick(1, 2'd0, 8'h12, 0);
    tick(1, 2'd0, 8'h34, 0);
    chk("R6 load low", statusReg, 8'h07);
    tick(1, 2'd2, 8'h00, 0);
    chk("R4 page poll", pollData, 8'hB4);
    chk("R7 success low", statusReg, 8'h0A);
    idle(PROG, 0);
    chk("R4 page done", pollData, 8'h34);
    chk("R6 load high", statusReg, 8'h0F);

    // R3 / R10: write byte and cycle length
    tick(1, 2'd1, 8'hC5, 0);
    chk("R3 write poll busy", pollData, 8'h45);
    busyCnt = 1;
    while (statusReg[0] == 1'b0 && busyCnt < 50) begin idle(1, 0); if (!statusReg[0]) busyCnt++; end
    chk("R10 busy length", 8'(busyCnt), 8'(PROG));
    chk("R3 write done", pollData, 8'hC5);

    // R5: erase
    tick(1, 2'd3, 8'h00, 0);
    chk("R5 erase poll", pollData, 8'h7F);
    idle(PROG, 0);
    chk("R5 erase done", pollData, 8'hFF);

    // R11 and R9 (busy): commands ignored mid-cycle
    tick(1, 2'd1, 8'h20, 0);
    tick(1, 2'd0, 8'h99, 0);
    chk("R11 load ignored flag", statusReg, 8'h0A);
    tick(1, 2'd1, 8'h66, 0);
    idle(PROG, 0);
    chk("R11 poll kept", pollData, 8'h20);

    // R8: brownout mid-cycle
    tick(1, 2'd1, 8'h5A, 0);
    idle(2, 1);
    chk("R8 inhibit status", statusReg, 8'h08);
    idle(PROG, 1);
    // R9: write ignored while inhibited
    tick(1, 2'd1, 8'h77, 1);
    chk("R9 poll unchanged", pollData, 8'h5A);
    chk("R9 status unchanged", statusReg, 8'h08);
    idle(3, 0);
    chk("R8 success stays low", statusReg, 8'h0B);

    // R7: clean cycle restores SUCCESS
    tick(1, 2'd3, 8'h00, 0);
    idle(PROG, 0);
    chk("R7 success high", statusReg, 8'h0F);

    // brownout arriving exactly at the completion edge
    tick(1, 2'd1, 8'h3C, 0);
    idle(PROG - 3, 0);
    idle(2, 1);
    chk("R8 late brownout", statusReg[2], 1'b0);
    idle(4, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic v; logic [1:0] op; logic [7:0] d; logic b;
      v  = ($urandom % 3) != 0;
      op = 2'($urandom);
      d  = 8'($urandom);
      b  = ($urandom % 16) == 0;
      tick(v, op, d, b);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule